// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps the outcome of finished transmissions until the host collects them. When the transmitter finishes a frame it presents a completion record: an interrupt-request flag and three error flags (jabber, underrun, maximum collisions). A record is stored only if it asks for an interrupt or carries an error. Successful, unflagged transmissions leave no trace. The host sees the oldest stored record as a status byte, and any host write to that register discards it so the next record becomes visible.

Storage depth is a parameter. When the store is full and no entry leaves in the same cycle, a new record is lost, and the entry the host currently sees is marked with an overflow flag. A jabber or underrun record halts the transmitter. A transmit FIFO overrun both halts it and raises an adapter-failure flag. Both conditions stay latched until a transmit reset or global reset command arrives, which also empties the store.

Top module: `txstat_stack`

## Requirements
- R1: `status_o` packs the oldest stored record as: bit 7 = 1 (record present), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (a later record was lost), bits 1..0 = 0.
- R2: With nothing stored, `status_o` reads 8'h00. A host write while empty changes nothing.
- R3: Records leave in the order they arrived. A host write removes the oldest, and the next record shows on `status_o` from the following cycle. Up to DEPTH records are held.
- R4: A push with none of the interrupt-request, jabber, underrun or maximum-collision flags set stores nothing and raises no event.
- R5: A qualifying push while DEPTH records are held, with no host write in the same cycle, is dropped. Bit 2 of the oldest record is set, and the other records are unchanged.
- R6: When the store is full, a qualifying push and a host write in the same cycle both take effect.
- R7: `tx_complete_o` pulses for one cycle, in the cycle after each qualifying push, whether the record was stored or dropped.
- R8: A qualifying push carrying jabber or underrun sets `tx_halt_o` from the next cycle, and it stays set until a transmit or global reset command.
- R9: `tx_overrun_i` sets both `adapter_fail_o` and `tx_halt_o` from the next cycle, and both stay set until a transmit or global reset command.
- R10: `tx_reset_i` or `global_reset_i` empties the store and clears the halt, failure and event outputs at the next edge. The reset command wins over a push or overrun in the same cycle.
- R11: While `rst_ni` is low, `status_o` is 8'h00 and `tx_complete_o`, `tx_halt_o` and `adapter_fail_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Transmission finished; record flags are valid |
| done_int_req_i | input | 1 | Interrupt on success requested |
| done_jabber_i | input | 1 | Jabber error |
| done_underrun_i | input | 1 | Transmit underrun error |
| done_max_coll_i | input | 1 | Maximum collisions reached |
| tx_overrun_i | input | 1 | Transmit FIFO overrun event |
| host_wr_i | input | 1 | Host write to status register (discard oldest) |
| tx_reset_i | input | 1 | Transmit reset command |
| global_reset_i | input | 1 | Global reset command |
| status_o | output | 8 | Oldest record as status byte |
| tx_complete_o | output | 1 | Completion event pulse |
| tx_halt_o | output | 1 | Transmitter disabled |
| adapter_fail_o | output | 1 | Adapter failure latched |

## Verification
The bench builds the block with DEPTH = 3. A depth that is not a power of two forces the read and write indices to wrap at a non-binary limit, and the store fills within a handful of pushes. All 16 flag combinations are pushed into an empty store one at a time. After that, a long pseudo-random stream keeps the store near full most of the time. This brings drops, same-cycle push and discard at full, and discards while empty within reach many times. Reset commands and overruns are scattered through the stream.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef struct packed {
    logic int_req;
    logic jabber;
    logic underrun;
    logic max_coll;
    logic lost;
  } txs_rec_t;

  function automatic logic [7:0] txs_byte(input txs_rec_t r, input logic valid);
    if (!valid) return 8'h00;
    return {1'b1, r.int_req, r.jabber, r.underrun, r.max_coll, r.lost, 2'b00};
  endfunction
endpackage

// File: rtl/txs_fmt.sv
module txs_fmt
  import txs_pkg::*;
(
  input  logic     done_i,
  input  logic     int_req_i,
  input  logic     jabber_i,
  input  logic     underrun_i,
  input  logic     max_coll_i,
  output logic     qual_o,
  output logic     fatal_o,
  output txs_rec_t rec_o
);
  logic any_err;

  always_comb begin
    any_err       = jabber_i | underrun_i | max_coll_i;
    qual_o        = done_i & (int_req_i | any_err);
    fatal_o       = qual_o & (jabber_i | underrun_i);
    rec_o.int_req  = int_req_i;
    rec_o.jabber   = jabber_i;
    rec_o.underrun = underrun_i;
    rec_o.max_coll = max_coll_i;
    rec_o.lost     = 1'b0;
  end
endmodule

// File: rtl/txs_store.sv
module txs_store
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     push_i,
  input  txs_rec_t rec_i,
  input  logic     pop_i,
  output txs_rec_t top_o,
  output logic     valid_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  txs_rec_t         mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push, drop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop  = pop_i & (cnt_q != '0);
    do_push = push_i & ((cnt_q != FULL) | do_pop);
    drop    = push_i & ~do_push;
    valid_o = (cnt_q != '0);
    top_o   = mem[head_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) begin
        mem[tail_q] <= rec_i;
        tail_q      <= nxt(tail_q);
      end
      // full without a departure: the visible entry records the loss
      if (drop) mem[head_q].lost <= 1'b1;
      if (do_pop) head_q <= nxt(head_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic qual_i,
  input  logic fatal_i,
  input  logic overrun_i,
  output logic evt_o,
  output logic halt_o,
  output logic fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o  <= 1'b0;
      halt_o <= 1'b0;
      fail_o <= 1'b0;
    end else if (clear_i) begin
      evt_o  <= 1'b0;
      halt_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      evt_o  <= qual_i;
      halt_o <= halt_o | fatal_i | overrun_i;
      fail_o <= fail_o | overrun_i;
    end
  end
endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       done_int_req_i,
  input  logic       done_jabber_i,
  input  logic       done_underrun_i,
  input  logic       done_max_coll_i,
  input  logic       tx_overrun_i,
  input  logic       host_wr_i,
  input  logic       tx_reset_i,
  input  logic       global_reset_i,
  output logic [7:0] status_o,
  output logic       tx_complete_o,
  output logic       tx_halt_o,
  output logic       adapter_fail_o
);
  logic     clear, qual, fatal, top_valid;
  txs_rec_t new_rec, top_rec;

  assign clear = tx_reset_i | global_reset_i;

  txs_fmt u_fmt (
    .done_i    (done_i),
    .int_req_i (done_int_req_i),
    .jabber_i  (done_jabber_i),
    .underrun_i(done_underrun_i),
    .max_coll_i(done_max_coll_i),
    .qual_o    (qual),
    .fatal_o   (fatal),
    .rec_o     (new_rec)
  );

  txs_store #(.DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .push_i (qual),
    .rec_i  (new_rec),
    .pop_i  (host_wr_i),
    .top_o  (top_rec),
    .valid_o(top_valid)
  );

  txs_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .qual_i   (qual),
    .fatal_i  (fatal),
    .overrun_i(tx_overrun_i),
    .evt_o    (tx_complete_o),
    .halt_o   (tx_halt_o),
    .fail_o   (adapter_fail_o)
  );

  assign status_o = txs_byte(top_rec, top_valid);
endmodule

// File: rtl/txstat_stack_chk.sv
module txstat_stack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_i,
  input logic       done_int_req_i,
  input logic       done_jabber_i,
  input logic       done_underrun_i,
  input logic       done_max_coll_i,
  input logic       tx_overrun_i,
  input logic       host_wr_i,
  input logic       tx_reset_i,
  input logic       global_reset_i,
  input logic [7:0] status_o,
  input logic       tx_complete_o,
  input logic       tx_halt_o,
  input logic       adapter_fail_o
);
  logic clr, q_push;
  assign clr    = tx_reset_i | global_reset_i;
  assign q_push = done_i & (done_int_req_i | done_jabber_i | done_underrun_i | done_max_coll_i);

  p_cmd_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (status_o == 8'h00) && !tx_halt_o && !adapter_fail_o && !tx_complete_o);

  p_evt_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && !clr) |=> tx_complete_o);

  p_no_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_push |=> !tx_complete_o);

  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_halt_o && !clr) |=> tx_halt_o);

  p_overrun_fail_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_overrun_i && !clr) |=> adapter_fail_o && tx_halt_o);

  p_empty_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[7] && host_wr_i && !q_push && !clr) |=> (status_o == 8'h00));
endmodule

bind txstat_stack txstat_stack_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .done_i         (done_i),
  .done_int_req_i (done_int_req_i),
  .done_jabber_i  (done_jabber_i),
  .done_underrun_i(done_underrun_i),
  .done_max_coll_i(done_max_coll_i),
  .tx_overrun_i   (tx_overrun_i),
  .host_wr_i      (host_wr_i),
  .tx_reset_i     (tx_reset_i),
  .global_reset_i (global_reset_i),
  .status_o       (status_o),
  .tx_complete_o  (tx_complete_o),
  .tx_halt_o      (tx_halt_o),
  .adapter_fail_o (adapter_fail_o)
);

// File: tb/txstat_stack_tb.sv
module txstat_stack_tb;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic done_i = 0, f_ir = 0, f_jb = 0, f_un = 0, f_mc = 0;
  logic ovr = 0, hwr = 0, txr = 0, gr = 0;
  logic [7:0] status_o;
  logic tx_complete_o, tx_halt_o, adapter_fail_o;

  int n_chk = 0, n_fail = 0;

  // model: index 0 is oldest; bits {int_req,jabber,underrun,max_coll,lost}
  logic [4:0] mq [D];
  int  mcnt = 0;
  bit  mh = 0, mf = 0, me = 0;

  always #5 clk = ~clk;

  txstat_stack #(.DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .done_i(done_i),
    .done_int_req_i(f_ir), .done_jabber_i(f_jb), .done_underrun_i(f_un),
    .done_max_coll_i(f_mc), .tx_overrun_i(ovr), .host_wr_i(hwr),
    .tx_reset_i(txr), .global_reset_i(gr), .status_o(status_o),
    .tx_complete_o(tx_complete_o), .tx_halt_o(tx_halt_o),
    .adapter_fail_o(adapter_fail_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_status();
    if (mcnt == 0) return 0;
    return 128 + (int'(mq[0]) << 2);
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "status", int'(status_o), exp_status());
    chk("R7", "event", int'(tx_complete_o), int'(me));
    chk("R8", "halt", int'(tx_halt_o), int'(mh));
    chk("R9", "fail", int'(adapter_fail_o), int'(mf));
  endtask

  task automatic cyc(input bit push, input logic [3:0] fl, input bit pop,
                     input bit ov, input bit tr, input bit g);
    string tag;
    bit qual, dpop, dpush;
    @(negedge clk);
    done_i = push; {f_ir, f_jb, f_un, f_mc} = fl;
    hwr = pop; ovr = ov; txr = tr; gr = g;
    @(posedge clk);
    #1;
    qual = push && (fl != 4'h0);
    if (tr || g) begin
      mcnt = 0; mh = 0; mf = 0; me = 0;
      tag = "R10";
    end else begin
      dpop  = pop && (mcnt > 0);
      dpush = qual && ((mcnt < D) || dpop);
      if (qual && !dpush) tag = "R5";
      else if (qual && dpop && mcnt == D) tag = "R6";
      else if (push && !qual) tag = "R4";
      else if (pop && mcnt == 0) tag = "R2";
      else tag = "R3";
      if (dpop) begin
        for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (dpush) begin
        mq[mcnt] = {fl, 1'b0};
        mcnt++;
      end
      if (qual && !dpush) mq[0][0] = 1'b1;
      me = qual;
      if (qual && (fl[2] || fl[1])) mh = 1;
      if (ov) begin mh = 1; mf = 1; end
    end
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < D; i++) mq[i] = '0;
    #23;
    // R11: outputs held clear under reset
    chk("R11", "status", int'(status_o), 0);
    chk("R11", "event", int'(tx_complete_o), 0);
    chk("R11", "halt", int'(tx_halt_o), 0);
    chk("R11", "fail", int'(adapter_fail_o), 0);
    @(negedge clk); rst_ni = 1'b1;

    // R1: exact byte for int_req + max_coll
    cyc(1, 4'b1001, 0, 0, 0, 0);
    chk("R1", "layout", int'(status_o), 8'hC8);
    cyc(0, 4'h0, 0, 0, 1, 0);

    // every flag combination alone, then discarded
    for (int c = 0; c < 16; c++) begin
      cyc(1, c[3:0], 0, 0, 0, 0);
      cyc(0, 4'h0, 1, 0, 0, 0);
      cyc(0, 4'h0, 1, 0, 0, 0);
      cyc(0, 4'h0, 0, 0, c[0], ~c[0]);
    end

    // R5: fill, overfill, then drain
    for (int k = 0; k < D + 2; k++) cyc(1, 4'b0001, 0, 0, 0, 0);
    chk("R5", "lost bit", int'(status_o[2]), 1);
    for (int k = 0; k < D + 1; k++) cyc(0, 4'h0, 1, 0, 0, 0);

    // R6: full, push and discard together
    for (int k = 0; k < D; k++) cyc(1, 4'b1000, 0, 0, 0, 0);
    cyc(1, 4'b0001, 1, 0, 0, 0);
    cyc(0, 4'h0, 0, 0, 1, 0);

    // R10: reset command wins over push and overrun
    cyc(1, 4'b0100, 0, 1, 0, 1);

    // pseudo-random stream
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[4:1], lf[5] & (lf[6] | lf[7]), (lf[15:10] == 6'h3F),
          (lf[14:9] == 6'h15), (lf[13:8] == 6'h2A));
    end

    // R11: async reset mid-run
    cyc(1, 4'b0110, 0, 1, 0, 0);
    @(negedge clk); rst_ni = 1'b0;
    #1;
    chk("R11", "status", int'(status_o), 0);
    chk("R11", "halt", int'(tx_halt_o), 0);
    chk("R11", "fail", int'(adapter_fail_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule